// File: doc/BRIEF.md
# LFSR Video Timing Generator

This block produces horizontal sync, vertical sync, display enable, and pulses that mark the start of each line and each frame for a raster display. It counts pixels and lines with two 16-bit maximal-length shift-register sequences instead of binary counters. A binary counter needs a carry chain. A sequence step needs only one 4-input XOR, so the counter logic depth stays fixed at any width. Because the sequence states have no numeric order, every timing point is given as the state the sequence reaches after the wanted number of steps from the all-ones seed. The block compares the running state against these encoded points. Each window (sync or display) uses a flag that is set at its opening state and cleared at its closing state.

Software or a mode loader converts a mode's binary counts into encoded comparator values. The package helper `lvt_pkg::lfsr_encode` does this conversion. The loader then drives the ten comparator inputs and a sync control code. Typical modes range from 640x480 to 2048x2048 active pixels. The comparator format is the same at any size.

Count mapping:
- Line counts run from 0 to the horizontal total minus one.
- Frame line counts run from 0 up to the vertical end count.
- Horizontal sync opens at count 1 and closes at its pulse width plus one.
- Vertical sync opens at count 0 and closes at its pulse width.
- Display windows open at total minus sync position and close after the active width or height.

Top module: `lvt_timing_gen`

## Requirements
- R1: While `rst_n` is low, all five outputs are 0. After release, both counters start at count 0, so `line_start` and `frame_start` are high one cycle after the first rising edge with reset released.
- R2: Each counter starts at seed 0xFFFF. Each step shifts the state left by one and inserts bit15 ^ bit4 ^ bit2 ^ bit1 as the new bit 0. The encoding of count N is the state after N steps from the seed, and every comparator input is taken in that encoding.
- R3: When the horizontal state equals `h_end`, the next state is the seed. With `h_end` = encode(T-1), `line_start` pulses exactly once every T cycles.
- R4: `hsync` is high for the horizontal counts c with `hs_on` ≤ c < `hs_off`. If the current count equals both the opening and closing values, closing wins.
- R5: The vertical counter steps once per line, when the horizontal counter wraps. It returns to the seed on the wrap that follows the line whose vertical state equals `v_end`. `vsync` is high for the vertical counts from `vs_on` up to, but not including, `vs_off`.
- R6: `de` is high only when the horizontal count lies in its display window and the vertical count lies in its own window. Each window opens at its `*_on` count and closes at its `*_off` count.
- R7: `frame_start` is high exactly when `line_start` is high for vertical count 0.
- R8: With sync control 0x01, `de` stays low. The counters, `hsync`, `vsync`, `line_start` and `frame_start` continue unchanged.
- R9: With sync control 0x07, both counters hold at the seed, all window flags clear, and every output is 0. After the code changes back, counting restarts from count 0 on both counters.
- R10: Any sync control value other than 0x01 and 0x07 behaves exactly like 0x00.
- R11: Every output is registered. Each output reflects the counter state from one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_ctl | input | 8 | Sync control code (0x00 run, 0x01 blank, 0x07 off) |
| h_end | input | 16 | Encoded last horizontal count of a line |
| hs_on | input | 16 | Encoded horizontal count where hsync opens |
| hs_off | input | 16 | Encoded horizontal count where hsync closes |
| hde_on | input | 16 | Encoded horizontal count where display opens |
| hde_off | input | 16 | Encoded horizontal count where display closes |
| v_end | input | 16 | Encoded last vertical count of a frame |
| vs_on | input | 16 | Encoded vertical count where vsync opens |
| vs_off | input | 16 | Encoded vertical count where vsync closes |
| vde_on | input | 16 | Encoded vertical count where display opens |
| vde_off | input | 16 | Encoded vertical count where display closes |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Display enable |
| line_start | output | 1 | One-cycle pulse at horizontal count 0 |
| frame_start | output | 1 | One-cycle pulse at horizontal and vertical count 0 |

## Verification
The assertions assume three things about the inputs:
- The comparator inputs are stable while the block runs.
- Every end value is a state the counter actually reaches within a line or frame.
- Every closing value is reachable after its opening value.

If any of these fails, a window could stay open forever or a counter could never wrap. The stimulus meets these assumptions in three ways:
- It derives all ten comparator values from one small binary mode.
- It picks the sync position beyond the active width, so the display window closes before the line ends.
- It changes the mode only while reset is held.

// File: rtl/lvt_pkg.sv
package lvt_pkg;

    // Tap set is fixed for a 16-bit maximal-length sequence.
    localparam int          LFSR_W    = 16;
    localparam logic [15:0] LFSR_SEED = 16'hFFFF;

    localparam int         CTL_W     = 8;
    localparam logic [7:0] CTL_BLANK = 8'h01;
    localparam logic [7:0] CTL_OFF   = 8'h07;

    // One sequence step.
    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
    endfunction

    // Comparator value for a binary count: state after n steps from the seed.
    function automatic logic [LFSR_W-1:0] lfsr_encode(input logic [LFSR_W-1:0] n);
        logic [LFSR_W-1:0] s;
        s = LFSR_SEED;
        for (int i = 0; i < (1 << LFSR_W); i++) begin
            if (i < int'(n)) s = lfsr_next(s);
        end
        return s;
    endfunction

    typedef struct packed {
        logic hsync;
        logic vsync;
        logic de;
        logic line_start;
        logic frame_start;
    } lvt_out_t;

endpackage

// File: rtl/lvt_lfsr_ctr.sv
module lvt_lfsr_ctr
    import lvt_pkg::*;
#(
    parameter int W = LFSR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         step,
    input  logic [W-1:0] end_val,
    output logic [W-1:0] state,
    output logic         at_end
);

    logic [W-1:0] st_d, st_q;

    always_comb begin
        at_end = (st_q == end_val);
        st_d   = st_q;
        if (hold)
            st_d = LFSR_SEED;
        else if (step)
            st_d = at_end ? LFSR_SEED : lfsr_next(st_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LFSR_SEED;
        else        st_q <= st_d;
    end

    assign state = st_q;

    // R2
    nonzero_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q != '0);

    // R3
    wrap_to_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && at_end) |=> (st_q == LFSR_SEED));

    // R9
    hold_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (st_q == LFSR_SEED));

endmodule

// File: rtl/lvt_window.sv
module lvt_window
    import lvt_pkg::*;
#(
    parameter int W = LFSR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] open_val,
    input  logic [W-1:0] close_val,
    output logic         active
);

    logic flag_d, flag_q;

    // Closing match wins over opening match; otherwise the flag holds.
    always_comb begin
        if (cnt == close_val)     active = 1'b0;
        else if (cnt == open_val) active = 1'b1;
        else                      active = flag_q;
        flag_d = clr ? 1'b0 : active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    // R4
    close_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == close_val) |-> !active);

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !clr) |=> ((cnt != close_val) && (cnt != open_val)) |-> active);

endmodule

// File: rtl/lvt_timing_gen.sv
module lvt_timing_gen
    import lvt_pkg::*;
#(
    parameter int CNT_W = LFSR_W,
    parameter int CW    = CTL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    sync_ctl,
    input  logic [CNT_W-1:0] h_end,
    input  logic [CNT_W-1:0] hs_on,
    input  logic [CNT_W-1:0] hs_off,
    input  logic [CNT_W-1:0] hde_on,
    input  logic [CNT_W-1:0] hde_off,
    input  logic [CNT_W-1:0] v_end,
    input  logic [CNT_W-1:0] vs_on,
    input  logic [CNT_W-1:0] vs_off,
    input  logic [CNT_W-1:0] vde_on,
    input  logic [CNT_W-1:0] vde_off,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic             line_start,
    output logic             frame_start
);

    logic             freeze, blank;
    logic [CNT_W-1:0] h_state, v_state;
    logic             h_at_end, v_at_end;
    logic             hs_act, vs_act, hde_act, vde_act;
    lvt_out_t         out_d, out_q;

    assign freeze = (sync_ctl == CW'(CTL_OFF));
    assign blank  = (sync_ctl == CW'(CTL_BLANK));

    lvt_lfsr_ctr #(.W(CNT_W)) u_hctr (
        .clk(clk), .rst_n(rst_n), .hold(freeze), .step(1'b1),
        .end_val(h_end), .state(h_state), .at_end(h_at_end)
    );

    lvt_lfsr_ctr #(.W(CNT_W)) u_vctr (
        .clk(clk), .rst_n(rst_n), .hold(freeze), .step(h_at_end),
        .end_val(v_end), .state(v_state), .at_end(v_at_end)
    );

    lvt_window #(.W(CNT_W)) u_hs (
        .clk(clk), .rst_n(rst_n), .clr(freeze), .cnt(h_state),
        .open_val(hs_on), .close_val(hs_off), .active(hs_act)
    );

    lvt_window #(.W(CNT_W)) u_vs (
        .clk(clk), .rst_n(rst_n), .clr(freeze), .cnt(v_state),
        .open_val(vs_on), .close_val(vs_off), .active(vs_act)
    );

    lvt_window #(.W(CNT_W)) u_hde (
        .clk(clk), .rst_n(rst_n), .clr(freeze), .cnt(h_state),
        .open_val(hde_on), .close_val(hde_off), .active(hde_act)
    );

    lvt_window #(.W(CNT_W)) u_vde (
        .clk(clk), .rst_n(rst_n), .clr(freeze), .cnt(v_state),
        .open_val(vde_on), .close_val(vde_off), .active(vde_act)
    );

    always_comb begin
        out_d             = '0;
        out_d.hsync       = !freeze && hs_act;
        out_d.vsync       = !freeze && vs_act;
        out_d.de          = !freeze && !blank && hde_act && vde_act;
        out_d.line_start  = !freeze && (h_state == LFSR_SEED);
        out_d.frame_start = !freeze && (h_state == LFSR_SEED) && (v_state == LFSR_SEED);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign hsync       = out_q.hsync;
    assign vsync       = out_q.vsync;
    assign de          = out_q.de;
    assign line_start  = out_q.line_start;
    assign frame_start = out_q.frame_start;

    // R9
    freeze_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> !(hsync || vsync || de || line_start || frame_start));

    // R8
    blank_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> !de);

    // R7
    frame_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> line_start);

    // R5
    v_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && !h_at_end) |=> (v_state == $past(v_state)));

    // R5
    v_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_at_end && v_at_end) |=> (v_state == LFSR_SEED));

endmodule

// File: tb/sim_lvt_timing_gen.sv
module sim_lvt_timing_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sync_ctl = 8'h00;
    logic [15:0] h_end, hs_on, hs_off, hde_on, hde_off;
    logic [15:0] v_end, vs_on, vs_off, vde_on, vde_off;
    logic        hsync, vsync, de, line_start, frame_start;

    always #2.5 clk = ~clk;

    lvt_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .sync_ctl(sync_ctl),
        .h_end(h_end), .hs_on(hs_on), .hs_off(hs_off),
        .hde_on(hde_on), .hde_off(hde_off),
        .v_end(v_end), .vs_on(vs_on), .vs_off(vs_off),
        .vde_on(vde_on), .vde_off(vde_off),
        .hsync(hsync), .vsync(vsync), .de(de),
        .line_start(line_start), .frame_start(frame_start)
    );

    // Mode table: htot, hact, hsync position, hsync width, vtot, vact, vsync position, vsync width, ctl
    localparam int NM = 5;
    localparam int HT[NM] = '{24, 30, 24, 18, 20};
    localparam int HA[NM] = '{12, 16, 12,  8, 10};
    localparam int HP[NM] = '{15, 20, 15, 10, 13};
    localparam int HW[NM] = '{ 4,  5,  4,  3,  2};
    localparam int VT[NM] = '{12,  9, 12,  8,  7};
    localparam int VA[NM] = '{ 6,  4,  6,  3,  4};
    localparam int VP[NM] = '{ 8,  6,  8,  5,  4};
    localparam int VW[NM] = '{ 2,  1,  2,  2,  1};
    localparam int CT[NM] = '{ 0,  0,  1,  0,  5};

    int checks = 0, errors = 0, cycles = 0;
    bit check_en = 1'b0;

    // Bench model in binary counts
    int ht, hds, hde_c, hsw, vt, vds, vde_c, vsw;
    int hc = 0, vc = 0;
    bit hsf, vsf, hdf, vdf;
    bit e_hs, e_vs, e_de, e_ls, e_fs;

    // R2: independent encoder, count -> state after n steps from 0xFFFF
    function automatic logic [15:0] enc(input int n);
        logic [15:0] s = 16'hFFFF;
        for (int i = 0; i < n; i++) s = {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
        return s;
    endfunction

    function automatic bit win(input int c, input int o, input int cl, input bit f);
        if (c == cl) return 1'b0;
        if (c == o)  return 1'b1;
        return f;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n || sync_ctl == 8'h07) begin
            {e_hs, e_vs, e_de, e_ls, e_fs} = '0;
            {hsf, vsf, hdf, vdf} = '0;
            hc = 0; vc = 0;
        end else begin
            hsf  = win(hc, 1, hsw + 1, hsf);
            vsf  = win(vc, 0, vsw, vsf);
            hdf  = win(hc, hds, hde_c, hdf);
            vdf  = win(vc, vds, vde_c, vdf);
            e_hs = hsf;
            e_vs = vsf;
            e_de = hdf && vdf && (sync_ctl != 8'h01);
            e_ls = (hc == 0);
            e_fs = (hc == 0) && (vc == 0);
            if (hc == ht - 1) begin
                hc = 0;
                vc = (vc == vt) ? 0 : vc + 1;
            end else hc++;
        end
    end

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cycles, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (check_en) begin
            string t;
            t = !rst_n ? "R1" : (sync_ctl == 8'h07) ? "R9" : (sync_ctl == 8'h05) ? "R10" : "R11";
            chk({t, " R4 hsync"}, hsync, e_hs);
            chk({t, " R5 vsync"}, vsync, e_vs);
            chk({t, (sync_ctl == 8'h01) ? " R8 de" : " R6 de"}, de, e_de);
            chk({t, " R2 R3 line_start"}, line_start, e_ls);
            chk({t, " R7 frame_start"}, frame_start, e_fs);
        end
    end

    task automatic load_mode(input int m);
        @(negedge clk);
        rst_n = 1'b0;
        ht = HT[m]; hsw = HW[m]; hds = HT[m] - HP[m]; hde_c = hds + HA[m];
        vt = VT[m]; vsw = VW[m]; vds = VT[m] - VP[m]; vde_c = vds + VA[m];
        h_end = enc(ht - 1); hs_on = enc(1); hs_off = enc(hsw + 1);
        hde_on = enc(hds); hde_off = enc(hde_c);
        v_end = enc(vt); vs_on = enc(0); vs_off = enc(vsw);
        vde_on = enc(vds); vde_off = enc(vde_c);
        sync_ctl = CT[m][7:0];
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        load_mode(0);
        rst_n = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 outputs in reset", hsync | vsync | de | line_start | frame_start, 1'b0);
        check_en = 1'b1;
        for (int m = 0; m < NM; m++) begin
            load_mode(m);
            repeat (2 * HT[m] * (VT[m] + 1) + 7) @(negedge clk);
        end
        // R1: first pulses one cycle after release
        load_mode(3);
        @(negedge clk);
        chk("R1 first line_start", line_start, 1'b1);
        chk("R1 first frame_start", frame_start, 1'b1);
        // R9: freeze mid-frame, then restart from count 0
        repeat (57) @(negedge clk);
        sync_ctl = 8'h07;
        repeat (40) @(negedge clk);
        chk("R9 frozen outputs", hsync | vsync | de | line_start, 1'b0);
        sync_ctl = 8'h00;
        @(negedge clk);
        chk("R9 restart frame_start", frame_start, 1'b1);
        repeat (300) @(negedge clk);
        // R8: switch to blank while running
        sync_ctl = 8'h01;
        repeat (200) @(negedge clk);
        sync_ctl = 8'h00;
        repeat (100) @(negedge clk);
        check_en = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule